// File: doc/BRIEF.md
# Configuration Bitstream Loader with CRC Gate

This block takes a configuration stream from an external host on the configuration clock, one bit per cycle or one byte per cycle. It checks a framed stream: a sync byte, a payload length, the payload bytes and a CRC over the payload. The running CRC is compared with the CRC carried in the frame. A match starts the wake-up of the device and opens a forwarding path that hands any later data to the next device in a daisy chain. A mismatch, or a bad sync byte, pulls the shared init line low and keeps the device in configuration.

The host can pause loading by raising its chip-select. The loader holds the host off with a busy output whenever it cannot take data: before loading is allowed, during the one-cycle CRC decision, and after an error. A mode input, sampled while reset is held, selects serial or byte-wide capture and whether the block runs the master configuration clock.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held and just after it is released, `busy` is 1 and `init_oe`, `done`, `wake_start` and `chain_valid` are 0.
- R2: Loading starts only once `prog_req` and `init_in` are both high; until then `busy` stays 1 and any data offered is ignored.
- R3: In byte mode (`mode_sel[0]`=1) one byte is taken on each rising clock edge with `cs_n` low and `busy` low. The frame is 0xA5, length high byte, length low byte, payload, CRC high byte, CRC low byte. With a good CRC, `done` rises and stays high and `wake_start` is high for exactly one cycle.
- R4: In serial mode (`mode_sel[0]`=0) one bit is taken per accepted edge on `din_serial`, most significant bit of each byte first, and the same frame is accepted.
- R5: The CRC is CRC-16 with polynomial 0x8005 (x^16+x^15+x^2+1), initial value 0, fed most significant bit first over the payload bytes only. A mismatch sets `init_oe` to 1, which holds while `prog_req` stays high, and `done` stays 0.
- R6: A first byte other than 0xA5 sets `init_oe` to 1 on the edge that takes it.
- R7: With `cs_n` high no data is taken and `mclk_run` is 0. In master mode (`mode_sel[1]`=1) `mclk_run` is 1 while a frame is loading and `cs_n` is low.
- R8: After the edge that takes the last CRC byte, `busy` is 1 for exactly one cycle while the CRC decision is made; `done` or `init_oe` follows on the next edge.
- R9: After a good frame, each accepted byte is driven on `chain_dout` with `chain_valid` high, both updated on the falling clock edge.
- R10: Driving `prog_req` low returns the block to idle on the next edge, clearing `done` and `init_oe`.
- R11: A frame with length 0 carries CRC 0x0000 and is accepted.
- R12: `mode_sel` is sampled only during reset; later changes have no effect on capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Bit 0: byte-wide capture; bit 1: master clocking (sampled in reset) |
| prog_req | input | 1 | Program request, high to allow loading |
| init_in | input | 1 | Sensed level of the shared init line |
| cs_n | input | 1 | Host chip-select, active low; high pauses |
| din_serial | input | 1 | Serial data input |
| din_byte | input | 8 | Byte-wide data input |
| init_oe | output | 1 | Pull-down enable for the init line (error) |
| busy | output | 1 | High while the loader cannot take data |
| mclk_run | output | 1 | Enable for the master configuration clock |
| done | output | 1 | Frame accepted with good CRC |
| wake_start | output | 1 | One-cycle pulse to start wake-up |
| chain_dout | output | 8 | Data forwarded to the next device |
| chain_valid | output | 1 | Forwarded data valid |

## Verification
The assertions assume the host changes `cs_n`, the data inputs and `prog_req` away from the clock edges and that `init_in` reflects the block's own pull-down together with any outside pull-down. The bench models the init line as a wired AND of the block's `init_oe` and a separate outside hold, and it drives every input two nanoseconds after a rising edge, so both clock edges see stable values. Mode changes are made only while reset is held, except in the test that checks they are ignored.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   localparam int BYTE_W = 8;
   localparam int CRC_W  = 16;

   typedef enum logic [3:0] {
      ST_IDLE, ST_SYNC, ST_LENH, ST_LENL, ST_DATA,
      ST_CRCH, ST_CRCL, ST_CHECK, ST_PASS, ST_ERR
   } ld_state_t;

   // One byte of a non-reflected CRC, most significant bit first.
   function automatic logic [CRC_W-1:0] crc_step_byte(
      input logic [CRC_W-1:0]  crc_in,
      input logic [BYTE_W-1:0] data,
      input logic [CRC_W-1:0]  poly);
      logic [CRC_W-1:0] c;
      c = crc_in;
      for (int i = BYTE_W - 1; i >= 0; i--) begin
         if (c[CRC_W-1] ^ data[i]) c = (c << 1) ^ poly;
         else                      c = c << 1;
      end
      return c;
   endfunction
endpackage

// File: rtl/cfg_capture.sv
module cfg_capture
   import cfg_loader_pkg::*;
#(
   parameter bit SERIAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              accept,
   input  logic              par_mode,
   input  logic              din_serial,
   input  logic [BYTE_W-1:0] din_byte,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_data
);
   localparam int CW = $clog2(BYTE_W);

   logic              ser_vld;
   logic [BYTE_W-1:0] ser_byte;

   generate
      if (SERIAL_EN) begin : g_serial
         logic [BYTE_W-2:0] shreg;
         logic [CW-1:0]     bitcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shreg  <= '0;
               bitcnt <= '0;
            end else if (clr) begin
               shreg  <= '0;
               bitcnt <= '0;
            end else if (accept && !par_mode) begin
               shreg  <= {shreg[BYTE_W-3:0], din_serial};
               bitcnt <= (bitcnt == CW'(BYTE_W - 1)) ? '0 : bitcnt + 1'b1;
            end
         end
         assign ser_vld  = accept && !par_mode && (bitcnt == CW'(BYTE_W - 1));
         assign ser_byte = {shreg, din_serial};
      end else begin : g_byte_only
         assign ser_vld  = 1'b0;
         assign ser_byte = '0;
      end
   endgenerate

   assign byte_vld  = par_mode ? accept : ser_vld;
   assign byte_data = par_mode ? din_byte : ser_byte;
endmodule

// File: rtl/cfg_crc16.sv
module cfg_crc16
   import cfg_loader_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY = 16'h8005,
   parameter logic [CRC_W-1:0] INIT = 16'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [BYTE_W-1:0] data,
   output logic [CRC_W-1:0]  crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= INIT;
      else if (clr) crc <= INIT;
      else if (en)  crc <= crc_step_byte(crc, data, POLY);
   end
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
   import cfg_loader_pkg::*;
#(
   parameter int               LEN_W     = 16,
   parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_req,
   input  logic              init_in,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [CRC_W-1:0]  crc_val,
   output ld_state_t         state,
   output logic              crc_clr,
   output logic              crc_en,
   output logic              wake_start
);
   logic [BYTE_W-1:0] len_hi, crc_hi, crc_lo;
   logic [LEN_W-1:0]  remain;
   logic [2*BYTE_W-1:0] len_full;
   logic              crc_ok;

   assign len_full = {len_hi, byte_data};
   assign crc_ok   = (crc_val == {crc_hi, crc_lo});
   assign crc_clr  = (state == ST_IDLE);
   assign crc_en   = (state == ST_DATA) && byte_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         len_hi     <= '0;
         crc_hi     <= '0;
         crc_lo     <= '0;
         remain     <= '0;
         wake_start <= 1'b0;
      end else begin
         wake_start <= (state == ST_CHECK) && crc_ok && prog_req;
         if (!prog_req) begin
            state <= ST_IDLE;
         end else begin
            unique case (state)
               ST_IDLE: if (init_in) state <= ST_SYNC;
               ST_SYNC: if (byte_vld)
                  state <= (byte_data == SYNC_BYTE) ? ST_LENH : ST_ERR;
               ST_LENH: if (byte_vld) begin
                  len_hi <= byte_data;
                  state  <= ST_LENL;
               end
               ST_LENL: if (byte_vld) begin
                  remain <= len_full[LEN_W-1:0];
                  state  <= (len_full[LEN_W-1:0] == '0) ? ST_CRCH : ST_DATA;
               end
               ST_DATA: if (byte_vld) begin
                  remain <= remain - 1'b1;
                  if (remain == LEN_W'(1)) state <= ST_CRCH;
               end
               ST_CRCH: if (byte_vld) begin
                  crc_hi <= byte_data;
                  state  <= ST_CRCL;
               end
               ST_CRCL: if (byte_vld) begin
                  crc_lo <= byte_data;
                  state  <= ST_CHECK;
               end
               ST_CHECK: state <= crc_ok ? ST_PASS : ST_ERR;
               default: state <= state;
            endcase
         end
      end
   end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfg_loader_pkg::*;
#(
   parameter int               LEN_W     = 16,
   parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'hA5,
   parameter logic [CRC_W-1:0]  CRC_POLY  = 16'h8005,
   parameter logic [CRC_W-1:0]  CRC_INIT  = 16'h0000,
   parameter bit               SERIAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic              prog_req,
   input  logic              init_in,
   input  logic              cs_n,
   input  logic              din_serial,
   input  logic [BYTE_W-1:0] din_byte,
   output logic              init_oe,
   output logic              busy,
   output logic              mclk_run,
   output logic              done,
   output logic              wake_start,
   output logic [BYTE_W-1:0] chain_dout,
   output logic              chain_valid
);
   generate
      if (LEN_W < 1 || LEN_W > 2 * BYTE_W) begin : g_bad_len
         $error("cfg_loader: LEN_W must be 1..16");
      end
      if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
         $error("cfg_loader: CRC polynomial must have its x^0 term");
      end
   endgenerate

   ld_state_t         state;
   logic              par_r, master_r;
   logic              accept, loading, pass;
   logic              byte_vld, crc_clr, crc_en;
   logic [BYTE_W-1:0] byte_data;
   logic [CRC_W-1:0]  crc_val;

   // Mode is captured only while reset is asserted.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_r    <= mode_sel[0] || !SERIAL_EN;
         master_r <= mode_sel[1];
      end
   end

   assign busy     = (state == ST_IDLE) || (state == ST_CHECK) || (state == ST_ERR);
   assign accept   = !cs_n && !busy;
   assign loading  = (state != ST_IDLE) && (state != ST_CHECK) &&
                     (state != ST_ERR)  && (state != ST_PASS);
   assign pass     = (state == ST_PASS);
   assign mclk_run = master_r && !cs_n && loading;
   assign init_oe  = (state == ST_ERR);
   assign done     = pass;

   cfg_capture #(.SERIAL_EN(SERIAL_EN)) u_cap (
      .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE), .accept(accept),
      .par_mode(par_r), .din_serial(din_serial), .din_byte(din_byte),
      .byte_vld(byte_vld), .byte_data(byte_data));

   cfg_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
      .data(byte_data), .crc(crc_val));

   cfg_ctrl #(.LEN_W(LEN_W), .SYNC_BYTE(SYNC_BYTE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .init_in(init_in),
      .byte_vld(byte_vld), .byte_data(byte_data), .crc_val(crc_val),
      .state(state), .crc_clr(crc_clr), .crc_en(crc_en),
      .wake_start(wake_start));

   // Daisy-chain passthrough, launched on the falling edge.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_dout  <= '0;
         chain_valid <= 1'b0;
      end else begin
         chain_valid <= pass && accept;
         if (pass && accept)
            chain_dout <= par_r ? din_byte : {{(BYTE_W-1){1'b0}}, din_serial};
      end
   end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
   input logic clk,
   input logic rst_n,
   input logic prog_req,
   input logic cs_n,
   input logic init_oe,
   input logic busy,
   input logic mclk_run,
   input logic done,
   input logic wake_start,
   input logic chain_valid
);
   p_no_done_with_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && init_oe));

   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (init_oe && prog_req) |=> init_oe);

   p_pause_stops_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !mclk_run);

   p_wake_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_start |=> !wake_start);

   p_done_after_check_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   p_restart_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_req |=> (!done && !init_oe && busy));

   p_chain_after_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chain_valid |-> done);
endmodule

bind cfg_loader cfg_loader_chk u_chk (
   .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .cs_n(cs_n),
   .init_oe(init_oe), .busy(busy), .mclk_run(mclk_run), .done(done),
   .wake_start(wake_start), .chain_valid(chain_valid));

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b01;
   logic       prog_req = 1'b0;
   logic       ext_low = 1'b0;
   logic       init_in;
   logic       cs_n = 1'b1;
   logic       din_serial = 1'b0;
   logic [7:0] din_byte = 8'h00;
   logic       init_oe, busy, mclk_run, done, wake_start, chain_valid;
   logic [7:0] chain_dout;

   int checks = 0;
   int errors = 0;
   bit par_mode = 1'b1;
   bit finished = 1'b0;
   logic [7:0] pl [8];

   always #5 clk = ~clk;
   assign init_in = !init_oe && !ext_low;

   cfg_loader u_cfg_loader (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .prog_req(prog_req),
      .init_in(init_in), .cs_n(cs_n), .din_serial(din_serial),
      .din_byte(din_byte), .init_oe(init_oe), .busy(busy),
      .mclk_run(mclk_run), .done(done), .wake_start(wake_start),
      .chain_dout(chain_dout), .chain_valid(chain_valid));

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int k = 0; k < 8; k++) begin
         logic fb = r[15] ^ b[7-k];
         r = {r[14:0], 1'b0};
         if (fb) r = r ^ 16'h8005;
      end
      return r;
   endfunction

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic do_reset(input logic [1:0] mode);
      rst_n = 1'b0; mode_sel = mode; prog_req = 1'b0; cs_n = 1'b1; ext_low = 1'b0;
      par_mode = mode[0];
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   task automatic start_load();
      prog_req = 1'b1;
      step(); step();
   endtask

   task automatic send_byte(input logic [7:0] b);
      if (par_mode) begin
         step(); din_byte = b; cs_n = 1'b0;
      end else begin
         for (int i = 7; i >= 0; i--) begin
            step(); din_serial = b[i]; cs_n = 1'b0;
         end
      end
   endtask

   task automatic send_frame(input int n, input bit corrupt);
      logic [15:0] c = 16'h0000;
      send_byte(8'hA5);
      send_byte(8'(n >> 8));
      send_byte(8'(n));
      for (int i = 0; i < n; i++) begin
         send_byte(pl[i]);
         c = ref_crc(c, pl[i]);
      end
      if (corrupt) c = c ^ 16'h0100;
      send_byte(c[15:8]);
      send_byte(c[7:0]);
   endtask

   // After the last CRC byte: one busy cycle, then the outcome.
   task automatic end_frame(input string req, input bit good);
      step(); cs_n = 1'b1;
      chk("R8", "busy in decision cycle", busy, 1);
      chk("R8", "done before decision", done, 0);
      step();
      chk(req, "done", done, good);
      chk(req, "init_oe", init_oe, !good);
      if (good) begin
         chk("R3", "wake pulse", wake_start, 1);
         chk("R8", "busy after pass", busy, 0);
         step();
         chk("R3", "wake pulse ends", wake_start, 0);
         chk("R3", "done holds", done, 1);
      end
   endtask

   task automatic t_reset();
      do_reset(2'b01);
      chk("R1", "busy", busy, 1);
      chk("R1", "init_oe", init_oe, 0);
      chk("R1", "done", done, 0);
      chk("R1", "wake", wake_start, 0);
      chk("R1", "chain_valid", chain_valid, 0);
   endtask

   task automatic t_not_ready();
      do_reset(2'b01);
      send_frame(2, 1'b0);
      step(); cs_n = 1'b1; step();
      chk("R2", "done without prog_req", done, 0);
      chk("R2", "busy without prog_req", busy, 1);
      ext_low = 1'b1; prog_req = 1'b1;
      repeat (3) step();
      chk("R2", "busy while init held low", busy, 1);
      ext_low = 1'b0;
      step();
      chk("R2", "busy drops once ready", busy, 0);
      send_frame(3, 1'b0);
      end_frame("R2", 1'b1);
   endtask

   task automatic t_par_good();
      do_reset(2'b01);
      start_load();
      send_frame(5, 1'b0);
      end_frame("R3", 1'b1);
   endtask

   task automatic t_serial_good();
      do_reset(2'b00);
      start_load();
      send_frame(3, 1'b0);
      end_frame("R4", 1'b1);
   endtask

   task automatic t_bad_crc();
      do_reset(2'b01);
      start_load();
      send_frame(4, 1'b1);
      end_frame("R5", 1'b0);
      repeat (3) step();
      chk("R5", "error holds", init_oe, 1);
      chk("R5", "no done after error", done, 0);
   endtask

   task automatic t_bad_sync();
      do_reset(2'b01);
      start_load();
      send_byte(8'hA4);
      step(); cs_n = 1'b1;
      chk("R6", "init_oe on bad sync", init_oe, 1);
      chk("R6", "busy on bad sync", busy, 1);
   endtask

   task automatic t_pause();
      logic [15:0] c = 16'h0000;
      do_reset(2'b11);
      start_load();
      send_byte(8'hA5);
      #1 chk("R7", "master clock runs", mclk_run, 1);
      send_byte(8'h00);
      send_byte(8'h02);
      step(); cs_n = 1'b1; din_byte = 8'hFF;
      #1 chk("R7", "master clock stopped", mclk_run, 0);
      repeat (3) step();
      chk("R7", "no error from paused junk", init_oe, 0);
      send_byte(pl[0]); c = ref_crc(c, pl[0]);
      send_byte(pl[1]); c = ref_crc(c, pl[1]);
      send_byte(c[15:8]);
      send_byte(c[7:0]);
      end_frame("R7", 1'b1);
   endtask

   task automatic t_chain();
      do_reset(2'b01);
      start_load();
      send_frame(1, 1'b0);
      end_frame("R9", 1'b1);
      send_byte(8'h3C);
      step(); cs_n = 1'b1;
      chk("R9", "chain data", chain_dout, 8'h3C);
      chk("R9", "chain valid", chain_valid, 1);
      step();
      chk("R9", "chain valid drops", chain_valid, 0);
   endtask

   task automatic t_restart();
      do_reset(2'b01);
      start_load();
      send_frame(2, 1'b1);
      end_frame("R10", 1'b0);
      prog_req = 1'b0;
      step();
      chk("R10", "error cleared", init_oe, 0);
      chk("R10", "idle busy", busy, 1);
      start_load();
      send_frame(2, 1'b0);
      end_frame("R10", 1'b1);
      prog_req = 1'b0;
      step();
      chk("R10", "done cleared", done, 0);
   endtask

   task automatic t_zero_len();
      do_reset(2'b01);
      start_load();
      send_frame(0, 1'b0);
      end_frame("R11", 1'b1);
   endtask

   task automatic t_mode_latch();
      do_reset(2'b00);
      mode_sel = 2'b11;
      start_load();
      send_frame(2, 1'b0);
      end_frame("R12", 1'b1);
      chk("R12", "no master clock after latch", mclk_run, 0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) pl[i] = 8'(8'h1F * (i + 1) ^ 8'h5A);
      t_reset();
      t_not_ready();
      t_par_good();
      t_serial_good();
      t_bad_crc();
      t_bad_sync();
      t_pause();
      t_chain();
      t_restart();
      t_zero_len();
      t_mode_latch();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule